// File: doc/BRIEF.md
# Shift-Register Clock Divider with Arbitrary Modulus

This block divides its clock by any whole number N from 2 up to 2^LEN-1. It does this with a shift register that has one feedback gate, not with a binary counter. The feedback is the XNOR of a chosen set of register bits, so the all-zeros pattern is a legal state and is used as the start of every period. At elaboration time a constant function works out which pattern the register holds after N-1 steps from all zeros. When the register holds that pattern, the next enabled clock loads all zeros again. The period is therefore exactly N enabled clocks, and the whole sequence costs one feedback gate and one compare against a constant.

With XNOR feedback and an even number of taps, the all-ones pattern maps onto itself. It is detected, and the register is sent back to all zeros on the next enabled clock.

The outputs are:
- a one-clock pulse in the terminal state;
- a square wave that changes level on every such pulse, giving the clock divided by 2N at 50% duty;
- the current register pattern, so that a neighbouring block can decode intermediate phases.

By default the register length is the smallest one whose maximal sequence holds N states. Default tap sets are built in for lengths 2 to 16. Other lengths need an explicit tap mask. Elaboration stops with an error in any of these cases:
- N is out of range;
- the tap set does not include the last stage;
- the tap count is odd;
- the computed terminal pattern is the all-ones state.

Top module: `lfsr_clkdiv`

## Requirements
- R1: A clock edge with `rst` high sets `phase_o` to all zeros and `square_o` to 0. Afterwards `tick_o` reads 0.
- R2: On an enabled clock, from a state that is neither the terminal state nor all ones, the register shifts toward its most significant bit. The new bit 0 is the XNOR of the bits selected by the tap mask, where bit i of the mask selects `phase_o[i]`.
- R3: On an enabled clock in the terminal state, `phase_o` becomes all zeros. The terminal state is the pattern reached after N-1 enabled clocks from all zeros.
- R4: While enabled, `tick_o` pulses exactly once every N enabled clocks. No `phase_o` value repeats within one period.
- R5: `tick_o` is 1 exactly when `phase_o` holds the terminal state.
- R6: `square_o` inverts on each enabled clock that sees `tick_o` high. Otherwise it keeps its value, so its period is 2N enabled clocks.
- R7: A clock edge with `en` low (and `rst` low) leaves `phase_o`, `tick_o` and `square_o` unchanged.
- R8: If the register holds all ones, the next enabled clock returns `phase_o` to all zeros. `square_o` is not changed by that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the divider |
| tick_o | output | 1 | High while the register holds the terminal state |
| square_o | output | 1 | Square wave at the clock divided by 2N |
| phase_o | output | LEN | Current shift-register pattern |

## Verification
The embedded properties check the following on every cycle:
- the reload to zero from the terminal state;
- the exit from the all-ones state;
- the freeze while disabled;
- the clearing on reset;
- the square wave changing exactly on enabled pulses;
- the terminal and lock-up decodes never being true together.

Other properties need whole-period observation, and only the bench scenarios can show them:
- the exact spacing of N enabled clocks between pulses;
- the absence of repeated patterns within a period;
- the correctness of the precomputed terminal pattern, for N = 2, 37, 63 and 32000.

The all-ones state cannot be reached from the ports. The bench therefore forces it into the register to show recovery.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

    localparam int unsigned MAXW = 32;

    // An affine map over GF(2): y = L*x ^ c.
    // Column i of L is the image of unit vector i.
    typedef struct packed {
        logic [MAXW*MAXW-1:0] cols;
        logic [MAXW-1:0]      c;
    } aff_t;

    function automatic logic [MAXW-1:0] width_mask(int unsigned len);
        return MAXW'((64'd1 << len) - 64'd1);
    endfunction

    // Smallest length whose maximal sequence (2^k - 1 states) covers n.
    function automatic int unsigned min_len(int unsigned n);
        int unsigned k;
        k = 2;
        for (int unsigned i = 2; i < MAXW; i++) begin
            if (((64'd1 << k) - 64'd1) < 64'(n)) k = i + 1;
        end
        return k;
    endfunction

    // Maximal-length tap masks; bit p-1 set means stage p feeds the gate.
    function automatic logic [MAXW-1:0] default_taps(int unsigned len);
        case (len)
            2:       return 32'h0000_0003;
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [MAXW-1:0] aff_apply(aff_t m, logic [MAXW-1:0] x);
        logic [MAXW-1:0] y;
        y = m.c;
        for (int unsigned i = 0; i < MAXW; i++) begin
            if (x[i]) y = y ^ m.cols[i*MAXW +: MAXW];
        end
        return y;
    endfunction

    // Returns the map that applies f first, then g.
    function automatic aff_t aff_compose(aff_t g, aff_t f);
        aff_t r;
        r.c = aff_apply(g, f.c);
        for (int unsigned i = 0; i < MAXW; i++) begin
            r.cols[i*MAXW +: MAXW] = aff_apply(g, f.cols[i*MAXW +: MAXW]) ^ g.c;
        end
        return r;
    endfunction

    function automatic aff_t aff_identity();
        aff_t r;
        r.c = '0;
        for (int unsigned i = 0; i < MAXW; i++) begin
            r.cols[i*MAXW +: MAXW] = MAXW'(64'd1 << i);
        end
        return r;
    endfunction

    // One register step: shift up, new bit 0 = XNOR of the tapped bits.
    function automatic aff_t aff_step(int unsigned len, logic [MAXW-1:0] taps);
        aff_t            r;
        logic [MAXW-1:0] col;
        r.c = MAXW'(1);
        for (int unsigned i = 0; i < MAXW; i++) begin
            col = '0;
            if (i < len) begin
                col = MAXW'(64'd1 << (i + 1)) & width_mask(len);
                if (taps[i]) col[0] = 1'b1;
            end
            r.cols[i*MAXW +: MAXW] = col;
        end
        return r;
    endfunction

    // The pattern after n-1 steps from zero, by repeated squaring of the step.
    function automatic logic [MAXW-1:0] term_state(int unsigned n, int unsigned len,
                                                   logic [MAXW-1:0] taps);
        aff_t        acc;
        aff_t        base;
        int unsigned e;
        acc  = aff_identity();
        base = aff_step(len, taps);
        e    = n - 1;
        for (int unsigned b = 0; b < MAXW; b++) begin
            if (e[b]) acc = aff_compose(base, acc);
            base = aff_compose(base, base);
        end
        return aff_apply(acc, '0) & width_mask(len);
    endfunction

    function automatic logic tap_parity(logic [MAXW-1:0] taps);
        return ^taps;
    endfunction

endpackage

// File: rtl/lfsr_div_core.sv
module lfsr_div_core #(
    parameter int unsigned     LEN  = 6,
    parameter logic [LEN-1:0]  TAPS = 6'b110000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           term_hit,
    input  logic           lock_hit,
    output logic [LEN-1:0] state
);

    typedef struct packed {
        logic [LEN-1:0] sr;
    } core_s;

    core_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (en) begin
            if (term_hit || lock_hit) r_d.sr = '0;
            else                      r_d.sr = {r_q.sr[LEN-2:0], ~^(r_q.sr & TAPS)};
        end
        if (rst) r_d.sr = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state = r_q.sr;

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (state == '0));

    a_r3_term_reload: assert property (@(posedge clk) disable iff (rst)
        (en && term_hit) |=> (state == '0));

    a_r8_lock_exit: assert property (@(posedge clk) disable iff (rst)
        (en && lock_hit) |=> (state == '0));

    a_r7_hold_state: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));

endmodule

// File: rtl/lfsr_div_decode.sv
module lfsr_div_decode #(
    parameter int unsigned     LEN  = 6,
    parameter logic [LEN-1:0]  TERM = '0
) (
    input  logic [LEN-1:0] state,
    output logic           term_hit,
    output logic           lock_hit
);

    always_comb begin
        term_hit = (state == TERM);
        lock_hit = &state;
    end

endmodule

// File: rtl/lfsr_div_toggle.sv
module lfsr_div_toggle (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic square
);

    typedef struct packed {
        logic sq;
    } tgl_s;

    tgl_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (en && tick) t_d.sq = ~t_q.sq;
        if (rst)        t_d.sq = 1'b0;
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign square = t_q.sq;

    a_r6_flip_on_tick: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (square != $past(square)));

    a_r7_square_still: assert property (@(posedge clk) disable iff (rst)
        !(en && tick) |=> $stable(square));

endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv
    import lfsr_div_pkg::*;
#(
    parameter int unsigned     DIV_N = 37,
    parameter int unsigned     LEN   = min_len(DIV_N),
    parameter logic [LEN-1:0]  TAPS  = LEN'(default_taps(LEN))
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    output logic           tick_o,
    output logic           square_o,
    output logic [LEN-1:0] phase_o
);

    localparam logic [LEN-1:0] TERM = LEN'(term_state(DIV_N, LEN, MAXW'(TAPS)));
    localparam longint unsigned MAXSEQ = (64'd1 << LEN) - 64'd1;

    if (LEN < 2 || LEN > MAXW) begin : g_bad_len
        $error("register length out of range");
    end
    if (DIV_N < 2 || 64'(DIV_N) > MAXSEQ) begin : g_bad_n
        $error("division ratio does not fit the register");
    end
    if (!TAPS[LEN-1]) begin : g_bad_msb
        $error("tap set must include the last stage");
    end
    if (tap_parity(MAXW'(TAPS))) begin : g_bad_parity
        $error("tap count must be even");
    end
    if (&TERM) begin : g_bad_term
        $error("terminal pattern falls on the lock-up state");
    end

    logic [LEN-1:0] state;
    logic           term_hit;
    logic           lock_hit;

    lfsr_div_core #(.LEN(LEN), .TAPS(TAPS)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .term_hit (term_hit),
        .lock_hit (lock_hit),
        .state    (state)
    );

    lfsr_div_decode #(.LEN(LEN), .TERM(TERM)) u_decode (
        .state    (state),
        .term_hit (term_hit),
        .lock_hit (lock_hit)
    );

    lfsr_div_toggle u_toggle (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (term_hit),
        .square (square_o)
    );

    assign tick_o  = term_hit;
    assign phase_o = state;

    a_r5_decode_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({term_hit, lock_hit}));

endmodule

// File: tb/lfsr_clkdiv_scope.sv
module lfsr_clkdiv_scope #(
    parameter string           NAME = "div",
    parameter int unsigned     N    = 37,
    parameter int unsigned     LEN  = 6,
    parameter logic [LEN-1:0]  TAPS = 6'b110000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           inj,
    input  logic [LEN-1:0] ph,
    input  logic           tk,
    input  logic           sq,
    output int             checks,
    output int             fails
);

    logic           e_edge, r_edge, valid, gap_ok;
    logic [LEN-1:0] ph_prev;
    logic           sq_prev;
    int unsigned    cnt, gap;
    int             period_id;
    int             seen [2**LEN];

    initial begin
        checks = 0; fails = 0; valid = 0; gap_ok = 0;
        cnt = 0; gap = 0; period_id = 1;
        e_edge = 0; r_edge = 0; ph_prev = '0; sq_prev = 0;
        for (int i = 0; i < 2**LEN; i++) seen[i] = 0;
    end

    task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", NAME, tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        e_edge = en;
        r_edge = rst;
    end

    always @(negedge clk) begin : samp
        logic [LEN-1:0] exp_ph;
        logic           exp_sq;
        int unsigned    cnt_new;
        logic           stepped;
        stepped = 0;
        exp_ph  = ph_prev;
        exp_sq  = sq_prev;
        cnt_new = cnt;
        if (r_edge) begin
            exp_ph = '0; exp_sq = 0; cnt_new = 0;
            period_id++; gap_ok = 0; gap = 0;
            seen[0] = period_id;
            valid = 1;
        end else if (valid && inj) begin
            exp_ph = '0; cnt_new = 0;
            period_id++; gap_ok = 0; gap = 0;
            seen[0] = period_id;
        end else if (valid && e_edge) begin
            stepped = 1;
            gap++;
            if (cnt == N - 1) begin
                exp_ph = '0; cnt_new = 0; exp_sq = ~sq_prev;
                period_id++;
            end else begin
                exp_ph  = {ph_prev[LEN-2:0], ~^(ph_prev & TAPS)};
                cnt_new = cnt + 1;
            end
        end
        if (valid) begin
            if (r_edge) begin
                chk("R1 reset phase", ph == '0, ph, 0);
                chk("R1 reset square", sq == 1'b0, sq, 0);
                chk("R1 reset tick", tk == 1'b0, tk, 0);
            end else if (inj) begin
                chk("R8 lock-up exit", ph == '0, ph, 0);
                chk("R8 square kept", sq == exp_sq, sq, exp_sq);
            end else if (!e_edge) begin
                chk("R7 phase held", ph == exp_ph, ph, exp_ph);
                chk("R7 square held", sq == exp_sq, sq, exp_sq);
                chk("R7 tick held", tk == (cnt_new == N - 1), tk, (cnt_new == N - 1));
            end else if (cnt_new == 0) begin
                chk("R3 reload to zero", ph == exp_ph, ph, exp_ph);
                chk("R6 square toggle", sq == exp_sq, sq, exp_sq);
            end else begin
                chk("R2 shift step", ph == exp_ph, ph, exp_ph);
                chk("R6 square steady", sq == exp_sq, sq, exp_sq);
            end
            if (!r_edge) chk("R5 tick decode", tk == (cnt_new == N - 1), tk, (cnt_new == N - 1));
            if (stepped && cnt_new != 0) begin
                chk("R4 no repeat", seen[ph] != period_id, seen[ph], period_id);
                seen[ph] = period_id;
            end
            if (stepped && cnt_new == 0) seen[0] = period_id;
            if (stepped && cnt_new == N - 1) begin
                if (gap_ok) chk("R4 tick spacing", gap == N, gap, N);
                gap_ok = 1;
                gap = 0;
            end
            if (!r_edge && !inj && cnt_new == N - 1 && !gap_ok) gap = 0;
        end
        ph_prev = ph;
        sq_prev = sq;
        cnt     = cnt_new;
    end

endmodule

// File: tb/lfsr_clkdiv_bench.sv
module lfsr_clkdiv_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic inj = 1'b0;

    always #5ns clk = ~clk;

    logic        tk_a, sq_a, tk_b, sq_b, tk_c, sq_c, tk_d, sq_d;
    logic [5:0]  ph_a, ph_b;
    logic [1:0]  ph_c;
    logic [14:0] ph_d;
    int          ca, fa, cb, fb, cc, fc, cd, fd;
    int          extra_checks = 0;
    int          extra_fails  = 0;
    logic        done = 1'b0;

    lfsr_clkdiv #(.DIV_N(37)) u_lfsr_clkdiv (
        .clk(clk), .rst(rst), .en(en), .tick_o(tk_a), .square_o(sq_a), .phase_o(ph_a));
    lfsr_clkdiv #(.DIV_N(63)) u_lfsr_clkdiv_n63 (
        .clk(clk), .rst(rst), .en(en), .tick_o(tk_b), .square_o(sq_b), .phase_o(ph_b));
    lfsr_clkdiv #(.DIV_N(2)) u_lfsr_clkdiv_n2 (
        .clk(clk), .rst(rst), .en(en), .tick_o(tk_c), .square_o(sq_c), .phase_o(ph_c));
    lfsr_clkdiv #(.DIV_N(32000), .LEN(15), .TAPS(15'h4001)) u_lfsr_clkdiv_n32000 (
        .clk(clk), .rst(rst), .en(en), .tick_o(tk_d), .square_o(sq_d), .phase_o(ph_d));

    lfsr_clkdiv_scope #(.NAME("n37"), .N(37), .LEN(6), .TAPS(6'b110000)) u_scope_a (
        .clk(clk), .rst(rst), .en(en), .inj(inj), .ph(ph_a), .tk(tk_a), .sq(sq_a),
        .checks(ca), .fails(fa));
    lfsr_clkdiv_scope #(.NAME("n63"), .N(63), .LEN(6), .TAPS(6'b110000)) u_scope_b (
        .clk(clk), .rst(rst), .en(en), .inj(1'b0), .ph(ph_b), .tk(tk_b), .sq(sq_b),
        .checks(cb), .fails(fb));
    lfsr_clkdiv_scope #(.NAME("n2"), .N(2), .LEN(2), .TAPS(2'b11)) u_scope_c (
        .clk(clk), .rst(rst), .en(en), .inj(1'b0), .ph(ph_c), .tk(tk_c), .sq(sq_c),
        .checks(cc), .fails(fc));
    lfsr_clkdiv_scope #(.NAME("n32000"), .N(32000), .LEN(15), .TAPS(15'h4001)) u_scope_d (
        .clk(clk), .rst(rst), .en(en), .inj(1'b0), .ph(ph_d), .tk(tk_d), .sq(sq_d),
        .checks(cd), .fails(fd));

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 ca + cb + cc + cd + extra_checks, fa + fb + fc + fd + extra_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1ns rst = 1'b0;
        for (int i = 0; i < 72000; i++) begin
            @(negedge clk);
            #1ns;
            en  = !((i % 97) == 50) && !(i >= 300 && i < 310);
            rst = (i >= 100 && i < 102);
        end
        @(negedge clk);
        #1ns en = 1'b1;
        repeat (5) @(negedge clk);
        // R8: plant the lock-up pattern, which no port sequence can reach
        #1ns;
        force u_lfsr_clkdiv.u_core.r_q = '1;
        inj = 1'b1;
        #1ns release u_lfsr_clkdiv.u_core.r_q;
        @(negedge clk);
        extra_checks++;
        if (ph_a != 6'd0) begin
            extra_fails++;
            $display("FAIL n37 R8 recovery in one clock actual=%0d expected=0", ph_a);
        end
        #1ns inj = 1'b0;
        repeat (200) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            extra_checks++;
            extra_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            report();
            $finish;
        end
    end

endmodule